// File: doc/BRIEF.md
# Color Lookup Table with Register Programming Port

This block holds a 256-entry color table. Each entry stores separate 8-bit red, green and blue values. A host programs the table through a two-word write window. A pixel pipeline reads any entry through an independent lookup port.

To program colors, the host first writes a start entry number to the pointer word. It then streams components to the color word. Every three color writes fill one entry in red, green, blue order. The entry pointer then moves on to the next entry and wraps from 255 back to 0, so a whole table or any run of it can be loaded after a single pointer write.

The lookup side takes an entry number and returns the packed 24-bit color on the next clock edge.

Top module: `clut_dac_top`

## Requirements
- R1: After reset, entries 0 to 254 read back as 0x000000 and entry 255 reads back as 0xFFFFFF. The lookup output is 0 while reset is held.
- R2: A write to word offset 0 (the pointer word) sets the entry pointer to bits 31:24 of the write data. Bits 23:0 of that write have no effect.
- R3: Writes to word offset 1 (the color word) store bits 31:24 of the write data into the pointed entry. The first, second and third writes go to red, green and blue in that order.
- R4: Each blue write moves the entry pointer forward by one, modulo 256, so entry 0 follows entry 255.
- R5: A pointer write returns the component sequence to red, even when it arrives part-way through an entry.
- R6: `lookupRgb` presents the entry named by `lookupIdx` at the previous rising edge. Red is in bits 23:16, green in 15:8 and blue in 7:0.
- R7: When a color write and a lookup of the same entry share a clock edge, the lookup returns the contents from before the write. The new value appears on the next lookup.
- R8: `busRdData` is zero at all times.
- R9: Writes to word offsets 2 and 3 change neither the table, the entry pointer nor the component sequence.
- R10: A color write changes only the one component selected by the sequence. The other two components of that entry keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Write strobe for the register window |
| busAddr | input | 2 | Word offset in the window |
| busWrData | input | 32 | Write data; only bits 31:24 are used |
| busRdData | output | 32 | Read data, always zero |
| lookupIdx | input | 8 | Entry number for the pixel-side lookup |
| lookupRgb | output | 24 | Registered color of the looked-up entry |

## Verification
A color write lands in the table at the edge that samples it. A lookup returns the table contents that are current at the edge after the lookup index is presented. The earliest point at which the bench can see a written value is therefore the second edge after the write was driven.

The bench drives all inputs on the falling edge. After presenting a lookup index it waits exactly one rising edge and compares at the following falling edge. It updates its reference table only once the write has been issued.

For the same-entry collision case, the bench drives the write and the lookup in the same cycle. It expects the old color one cycle later and the new color one cycle after that. This separates a correct one-cycle pipeline from a write-through or a two-cycle one.

// File: rtl/clut_pkg.sv
package clut_pkg;
  parameter int IDX_W  = 8;
  parameter int COMP_W = 8;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int NCOMP   = 3;
  localparam int RGB_W   = NCOMP * COMP_W;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_t;

  // one strobe per component: bit 0 red, bit 1 green, bit 2 blue
  typedef struct packed {
    logic [NCOMP-1:0]  compWr;
    logic [IDX_W-1:0]  addr;
    logic [COMP_W-1:0] val;
  } clut_wr_t;
endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 2,
  parameter int IDX_OFFS  = 0,
  parameter int DATA_OFFS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output clut_wr_t          wrStb
);
  localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_OFFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFFS);

  logic [IDX_W-1:0]  idxQ;
  phase_t            phaseQ;
  logic              idxHit, dataHit;
  logic [IDX_W-1:0]  idxByte;
  logic [COMP_W-1:0] compByte;

  assign idxHit   = busWrEn && (busAddr == IDX_A);
  assign dataHit  = busWrEn && (busAddr == DATA_A);
  assign idxByte  = busWrData[BUS_W-1 -: IDX_W];
  assign compByte = busWrData[BUS_W-1 -: COMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxQ   <= '0;
      phaseQ <= PH_RED;
    end else if (idxHit) begin
      idxQ   <= idxByte;
      phaseQ <= PH_RED;
    end else if (dataHit) begin
      unique case (phaseQ)
        PH_RED:  phaseQ <= PH_GRN;
        PH_GRN:  phaseQ <= PH_BLU;
        default: begin
          phaseQ <= PH_RED;
          idxQ   <= idxQ + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    wrStb.compWr = '0;
    if (dataHit) begin
      unique case (phaseQ)
        PH_RED:  wrStb.compWr = 3'b001;
        PH_GRN:  wrStb.compWr = 3'b010;
        default: wrStb.compWr = 3'b100;
      endcase
    end
    wrStb.addr = idxQ;
    wrStb.val  = compByte;
  end

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wrStb.compWr));

  // R4
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrStb.compWr[2] |=> (idxQ == IDX_W'($past(idxQ) + 1'b1)) && (phaseQ == PH_RED));

  // R5
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idxHit |=> (phaseQ == PH_RED) && (idxQ == $past(idxByte)));

  // R9
  other_offs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idxHit && !dataHit) |=> $stable(idxQ) && $stable(phaseQ));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  clut_wr_t         wrStb,
  input  logic [IDX_W-1:0] lookupIdx,
  output logic [RGB_W-1:0] lookupRgb
);
  for (genvar c = 0; c < NCOMP; c++) begin : compGen
    logic [COMP_W-1:0] tab [ENTRIES];
    logic [COMP_W-1:0] rdQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < ENTRIES; e++)
          tab[e] <= (e == ENTRIES - 1) ? '1 : '0;
      end else if (wrStb.compWr[c]) begin
        tab[wrStb.addr] <= wrStb.val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdQ <= '0;
      else        rdQ <= tab[lookupIdx];
    end

    // R3
    comp_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrStb.compWr[c] |=> tab[$past(wrStb.addr)] == $past(wrStb.val));
  end

  // red in the top byte, blue in the bottom byte
  assign lookupRgb = {compGen[0].rdQ, compGen[1].rdQ, compGen[2].rdQ};
endmodule

// File: rtl/clut_dac_top.sv
module clut_dac_top
  import clut_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic [IDX_W-1:0]  lookupIdx,
  output logic [RGB_W-1:0]  lookupRgb
);
  clut_wr_t wrStb;

  clut_ctrl #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .IDX_OFFS(0), .DATA_OFFS(1)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .wrStb    (wrStb)
  );

  clut_store store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrStb    (wrStb),
    .lookupIdx(lookupIdx),
    .lookupRgb(lookupRgb)
  );

  assign busRdData = '0;
endmodule

// File: tb/clut_dac_top_tb_top.sv
`timescale 1ns/1ps
module clut_dac_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  lookupIdx = '0;
  logic [23:0] lookupRgb;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0] refR [256];
  logic [7:0] refG [256];
  logic [7:0] refB [256];
  logic [7:0] refIdx;
  int         refPh;

  always #2 clk = ~clk;

  clut_dac_top dut_i (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .lookupIdx(lookupIdx), .lookupRgb(lookupRgb)
  );

  function automatic logic [23:0] expRgb(input logic [7:0] i);
    return {refR[i], refG[i], refB[i]};
  endfunction

  task automatic modelWrite(input logic [1:0] a, input logic [31:0] d);
    if (a == 2'd0) begin
      refIdx = d[31:24];
      refPh  = 0;
    end else if (a == 2'd1) begin
      case (refPh)
        0: refR[refIdx] = d[31:24];
        1: refG[refIdx] = d[31:24];
        default: begin
          refB[refIdx] = d[31:24];
          refIdx = refIdx + 8'd1;
        end
      endcase
      refPh = (refPh + 1) % 3;
    end
  endtask

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    modelWrite(a, d);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic lookupChk(input string req, input logic [7:0] i);
    @(negedge clk);
    lookupIdx = i;
    @(negedge clk);
    checkEq(req, {8'h0, lookupRgb}, {8'h0, expRgb(i)});
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    logic [23:0] oldRgb;
    for (int i = 0; i < 256; i++) begin
      refR[i] = (i == 255) ? 8'hFF : 8'h00;
      refG[i] = refR[i];
      refB[i] = refR[i];
    end
    refIdx = 8'd0;
    refPh  = 0;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    checkEq("R1 output in reset", {8'h0, lookupRgb}, 32'h0);
    checkEq("R8 read data", busRdData, 32'h0);
    rst_n = 1'b1;

    // R1: power-up contents
    for (int i = 0; i < 256; i++) lookupChk("R1 reset entry", 8'(i));
    checkEq("R1 white entry", {8'h0, expRgb(8'hFF)}, 32'h00FFFFFF);

    // R2, R3, R6: pointer then three components
    busWr(2'd0, 32'h05ABCDEF);
    busWr(2'd1, 32'h11000000);
    busWr(2'd1, 32'h22FFFFFF);
    busWr(2'd1, 32'h33123456);
    lookupChk("R3 rgb order", 8'd5);
    checkEq("R6 packing", {8'h0, expRgb(8'd5)}, 32'h00112233);
    lookupChk("R2 low bits ignored", 8'd171);

    // R4: wrap from 255 to 0
    busWr(2'd0, 32'hFF000000);
    for (int k = 0; k < 6; k++) busWr(2'd1, {8'(8'h40 + k), 24'h0});
    lookupChk("R4 entry 255", 8'd255);
    lookupChk("R4 wrapped entry 0", 8'd0);
    checkEq("R4 wrap value", {8'h0, expRgb(8'd0)}, 32'h00434445);

    // R5: pointer write mid-entry restarts at red
    busWr(2'd0, 32'h07000000);
    busWr(2'd1, 32'h99000000);
    busWr(2'd0, 32'h07000000);
    busWr(2'd1, 32'h44000000);
    busWr(2'd1, 32'h55000000);
    busWr(2'd1, 32'h66000000);
    lookupChk("R5 restart", 8'd7);
    checkEq("R5 value", {8'h0, expRgb(8'd7)}, 32'h00445566);
    lookupChk("R4 pointer after restart", 8'd8);

    // R10: red-only update keeps green and blue
    busWr(2'd0, 32'h05000000);
    busWr(2'd1, 32'h77000000);
    busWr(2'd0, 32'h14000000);
    lookupChk("R10 partial", 8'd5);
    checkEq("R10 value", {8'h0, expRgb(8'd5)}, 32'h00772233);

    // R9: other offsets ignored mid-entry
    busWr(2'd0, 32'h0A000000);
    busWr(2'd1, 32'hA1000000);
    busWr(2'd2, 32'h0B000000);
    busWr(2'd3, 32'hEE000000);
    busWr(2'd1, 32'hA2000000);
    busWr(2'd1, 32'hA3000000);
    lookupChk("R9 ignored offsets", 8'd10);
    checkEq("R9 value", {8'h0, expRgb(8'd10)}, 32'h00A1A2A3);
    lookupChk("R9 entry 11 untouched", 8'd11);

    // R7: write and lookup of the same entry on one edge
    busWr(2'd0, 32'h0C000000);
    busWr(2'd1, 32'h12000000);
    busWr(2'd1, 32'h34000000);
    @(negedge clk);
    oldRgb = expRgb(8'd12);
    busWrEn = 1'b1; busAddr = 2'd1; busWrData = 32'h56000000;
    lookupIdx = 8'd12;
    modelWrite(2'd1, 32'h56000000);
    @(negedge clk);
    busWrEn = 1'b0;
    checkEq("R7 old value", {8'h0, lookupRgb}, {8'h0, oldRgb});
    @(negedge clk);
    checkEq("R7 new value", {8'h0, lookupRgb}, 32'h00123456);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2)       busWr(2'd0, $urandom());
      else if (op < 6)  busWr(2'd1, $urandom());
      else if (op < 7)  busWr(2'($urandom_range(2, 3)), $urandom());
      else begin
        lookupChk("R6 random lookup", 8'($urandom_range(0, 255)));
        checkEq("R8 read data", busRdData, 32'h0);
      end
    end
    for (int i = 0; i < 256; i++) lookupChk("R3 final sweep", 8'(i));

    report();
  end
endmodule